// File: doc/BRIEF.md
# ADC Queue Single-Pass Scan Controller

This block sequences one conversion queue of a multi-channel ADC through a single pass. A configuration write selects how the pass is launched (software, rising edge on an external pin, external gate level, or a periodic timer tick) and can arm the pass in the same write. Once armed, the chosen launch condition starts the queue at command word zero. The block then hands one conversion at a time to a conversion engine, advances the command-word index on each completion, and finishes at an end-of-queue marker or at the last slot. On finishing, it disarms itself, returns to idle and raises a sticky completion flag.

Software can only arm the pass. Only the controller disarms it. Arming writes made while the queue is running change nothing. A write that changes the launch mode applies at once: it aborts any conversion that is outstanding, idles the queue and loads the arm value carried by that write. A trigger that arrives while the queue runs in edge or timer mode sets a sticky overrun flag. An instance built as the second queue refuses the gated mode.

Top module: `adc_single_scan_ctl`

## Requirements
- R1: After reset the queue is idle, `cmd_idx` is 0, `conv_start`, `done_flag`, `done_irq` and `trig_ovr` are low, and the mode reads 0 (software).
- R2: While the queue is not armed, edges on `ext_trig`, a high level on `ext_trig` and pulses on `tmr_expire` start nothing. This holds in edge mode (1), gated mode (2) and timer mode (3).
- R3: A configuration write with `cfg_scan_en`=0 that keeps the mode unchanged does not disarm an armed queue. Its next trigger still runs the pass.
- R4: In software mode (0), a write with `cfg_scan_en`=1 starts the queue without an external event, and the queue is active two clock edges after the write edge.
- R5: A pass issues exactly one `conv_start` per command word, for indices 0, 1, 2 and so on in order. It ends after the conversion of the word that has `cmd_end` high, or after index QUEUE_LEN-1 when no marker is seen.
- R6: When a pass completes, the queue goes idle, `cmd_idx` returns to 0 and the arm bit clears, so no further trigger starts a pass until software arms it again.
- R7: A configuration write with the same mode during a pass, whatever its arm value, neither restarts nor stops the pass and leaves the queue disarmed at its end.
- R8: A write that changes the mode aborts the pass at once. `conv_abort` pulses if a conversion is outstanding, the queue goes idle with index 0, and the arm value in that write is applied under the new mode.
- R9: A rising edge on `ext_trig` in edge mode, or a `tmr_expire` pulse in timer mode, while the queue is active sets `trig_ovr` until `ovr_clr`. Gated mode never sets it.
- R10: In timer mode the first `tmr_expire` after arming starts the pass. After completion, pulses do nothing until the queue is re-armed, and a re-armed pass starts again at index 0.
- R11: In gated mode a high `ext_trig` starts an armed queue. A low gate holds back new conversions without ending the pass, and raising the gate resumes at the held index.
- R12: With SECOND_QUEUE=1, a write selecting gated mode (2) is dropped entirely: the mode and the arm bit keep their previous values.
- R13: `done_flag` stays set from completion until a `flag_clr` pulse. `done_irq` is high exactly while `done_flag` is set and the last written `cfg_irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Launch mode: 0 software, 1 edge, 2 gated, 3 timer |
| cfg_scan_en | input | 1 | Arm value carried by the write (set-only) |
| cfg_irq_en | input | 1 | Completion interrupt enable |
| flag_clr | input | 1 | Clears the completion flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| ext_trig | input | 1 | External trigger or gate pin |
| tmr_expire | input | 1 | Periodic timer expiry pulse |
| cmd_end | input | 1 | End-of-queue marker of the word at `cmd_idx` |
| conv_done | input | 1 | Conversion engine finished the current word |
| conv_start | output | 1 | Request conversion of word `cmd_idx` |
| conv_abort | output | 1 | Cancel the outstanding conversion |
| cmd_idx | output | IDX_W | Current command-word index |
| queue_active | output | 1 | Queue status: 1 active, 0 idle |
| mode_rd | output | 2 | Current launch mode |
| done_flag | output | 1 | Sticky completion flag |
| done_irq | output | 1 | Completion interrupt request |
| trig_ovr | output | 1 | Sticky trigger-overrun flag |

## Verification
The assertions assume that the conversion engine raises `conv_done` only for a conversion it has accepted and not had aborted, and that `cmd_end` is stable while a word is current. The bench models the engine as a responder with a programmable latency. The responder drops its pending work on `conv_abort` and derives `cmd_end` from `cmd_idx`, so both assumptions hold. The sweep covers every marker position, including no marker at all, and several latencies.

// File: rtl/adc_single_scan_ctl.sv
module adc_single_scan_ctl #(
  parameter int QUEUE_LEN    = 16,
  parameter bit SECOND_QUEUE = 1'b0,
  localparam int IDX_W = (QUEUE_LEN > 1) ? $clog2(QUEUE_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_scan_en,
  input  logic             cfg_irq_en,
  input  logic             flag_clr,
  input  logic             ovr_clr,
  input  logic             ext_trig,
  input  logic             tmr_expire,
  input  logic             cmd_end,
  input  logic             conv_done,
  output logic             conv_start,
  output logic             conv_abort,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             queue_active,
  output logic [1:0]       mode_rd,
  output logic             done_flag,
  output logic             done_irq,
  output logic             trig_ovr
);

  localparam logic [1:0] M_SW   = 2'd0;
  localparam logic [1:0] M_EDGE = 2'd1;
  localparam logic [1:0] M_GATE = 2'd2;
  localparam logic [1:0] M_TMR  = 2'd3;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(QUEUE_LEN - 1);

  logic [1:0]       mode_q;
  logic             arm_q, act_q, busy_q, ext_q, flag_q, ie_q, ovr_q;
  logic [IDX_W-1:0] idx_q;
  logic             trig;

  wire accept   = cfg_wr && !(SECOND_QUEUE && cfg_mode == M_GATE);
  wire mode_chg = accept && (cfg_mode != mode_q);
  wire ext_rise = ext_trig && !ext_q;
  wire run_ok   = (mode_q != M_GATE) || ext_trig;
  wire last     = cmd_end || (idx_q == LAST_IDX);
  wire retire   = act_q && busy_q && conv_done && !mode_chg;
  wire finish   = retire && last;
  wire launch   = arm_q && !act_q && trig && !mode_chg;
  wire ovr_evt  = act_q && ((mode_q == M_EDGE && ext_rise) ||
                            (mode_q == M_TMR  && tmr_expire));

  always_comb begin
    case (mode_q)
      M_SW:    trig = 1'b1;
      M_EDGE:  trig = ext_rise;
      M_GATE:  trig = ext_trig;
      default: trig = tmr_expire;
    endcase
  end

  assign conv_start   = act_q && !busy_q && run_ok && !mode_chg;
  assign conv_abort   = mode_chg && busy_q;
  assign cmd_idx      = idx_q;
  assign queue_active = act_q;
  assign mode_rd      = mode_q;
  assign done_flag    = flag_q;
  assign done_irq     = flag_q && ie_q;
  assign trig_ovr     = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_SW;
      arm_q  <= 1'b0;
      act_q  <= 1'b0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      ext_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      if (accept) ie_q <= cfg_irq_en;
      if (mode_chg) begin
        mode_q <= cfg_mode;
        arm_q  <= cfg_scan_en;
        act_q  <= 1'b0;
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        if (accept && !act_q && cfg_scan_en) arm_q <= 1'b1;
        if (launch) begin
          act_q <= 1'b1;
          idx_q <= '0;
        end
        if (conv_start) busy_q <= 1'b1;
        if (retire) begin
          busy_q <= 1'b0;
          if (last) begin
            act_q <= 1'b0;
            arm_q <= 1'b0;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (finish)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (ovr_evt)       ovr_q  <= 1'b1;
      else if (ovr_clr)  ovr_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_single_scan_ctl_chk.sv
module adc_single_scan_ctl_chk #(
  parameter int QUEUE_LEN    = 16,
  parameter bit SECOND_QUEUE = 1'b0,
  localparam int IDX_W = (QUEUE_LEN > 1) ? $clog2(QUEUE_LEN) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_start,
  input logic             conv_abort,
  input logic [IDX_W-1:0] cmd_idx,
  input logic             queue_active,
  input logic [1:0]       mode_rd,
  input logic             done_flag,
  input logic             done_irq,
  input logic             trig_ovr
);

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cmd_idx) <= QUEUE_LEN - 1);

  // R5
  start_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> queue_active);

  // R8
  abort_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> (!queue_active && cmd_idx == '0));

  // R6
  flag_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> (!queue_active && $past(queue_active)));

  // R13
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> done_flag);

  // R9
  ovr_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_ovr) |-> ($past(queue_active) && mode_rd != 2'd2));

  generate
    if (SECOND_QUEUE) begin : g_q2
      // R12
      no_gate_q2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd != 2'd2);
    end
  endgenerate

endmodule

bind adc_single_scan_ctl adc_single_scan_ctl_chk #(
  .QUEUE_LEN(QUEUE_LEN),
  .SECOND_QUEUE(SECOND_QUEUE)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .conv_start(conv_start),
  .conv_abort(conv_abort),
  .cmd_idx(cmd_idx),
  .queue_active(queue_active),
  .mode_rd(mode_rd),
  .done_flag(done_flag),
  .done_irq(done_irq),
  .trig_ovr(trig_ovr)
);

// File: tb/test_adc_single_scan_ctl.sv
`timescale 1ns/1ps
module test_adc_single_scan_ctl;
  localparam int QL = 4;
  localparam logic [1:0] SW = 2'd0, EDGE = 2'd1, GATE = 2'd2, TMR = 2'd3;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_scan_en = 0, cfg_irq_en = 0, flag_clr = 0, ovr_clr = 0;
  logic [1:0] cfg_mode = 0;
  logic ext_trig = 0, tmr_expire = 0, conv_done = 0, cmd_end;
  logic conv_start, conv_abort, queue_active, done_flag, done_irq, trig_ovr;
  logic [1:0] cmd_idx, mode_rd;
  logic q2_wr = 0;
  logic q2_start, q2_abort, q2_act, q2_flag, q2_irq, q2_ovr;
  logic [1:0] q2_idx, q2_mode;

  int end_pos = 3, lat = 1, n_start = 0, n_abort = 0, cnt = 0;
  bit pend = 0;
  int seq [0:15];
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;
  assign cmd_end = (int'(cmd_idx) == end_pos);

  adc_single_scan_ctl #(.QUEUE_LEN(QL), .SECOND_QUEUE(1'b0)) i_adc_single_scan_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_scan_en(cfg_scan_en), .cfg_irq_en(cfg_irq_en), .flag_clr(flag_clr),
    .ovr_clr(ovr_clr), .ext_trig(ext_trig), .tmr_expire(tmr_expire),
    .cmd_end(cmd_end), .conv_done(conv_done), .conv_start(conv_start),
    .conv_abort(conv_abort), .cmd_idx(cmd_idx), .queue_active(queue_active),
    .mode_rd(mode_rd), .done_flag(done_flag), .done_irq(done_irq), .trig_ovr(trig_ovr));

  adc_single_scan_ctl #(.QUEUE_LEN(QL), .SECOND_QUEUE(1'b1)) i_adc_single_scan_ctl_q2 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(q2_wr), .cfg_mode(cfg_mode),
    .cfg_scan_en(cfg_scan_en), .cfg_irq_en(cfg_irq_en), .flag_clr(1'b0),
    .ovr_clr(1'b0), .ext_trig(1'b0), .tmr_expire(tmr_expire),
    .cmd_end(1'b0), .conv_done(1'b0), .conv_start(q2_start),
    .conv_abort(q2_abort), .cmd_idx(q2_idx), .queue_active(q2_act),
    .mode_rd(q2_mode), .done_flag(q2_flag), .done_irq(q2_irq), .trig_ovr(q2_ovr));

  // conversion engine model
  always @(negedge clk) begin
    conv_done = 0;
    if (!rst_n) pend = 0;
    else if (conv_abort) begin pend = 0; n_abort++; end
    else if (pend) begin
      if (cnt == 0) begin conv_done = 1; pend = 0; end
      else cnt--;
    end else if (conv_start) begin
      seq[n_start] = int'(cmd_idx);
      n_start++;
      pend = 1;
      cnt = lat;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input bit en, input bit ie);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_mode = m; cfg_scan_en = en; cfg_irq_en = ie;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic pulse(input bit which_tmr);
    @(posedge clk); #1;
    if (which_tmr) tmr_expire = 1; else ext_trig = 1;
    @(posedge clk); #1;
    tmr_expire = 0; ext_trig = 0;
  endtask

  task automatic clr(input bit f, input bit o);
    @(posedge clk); #1; flag_clr = f; ovr_clr = o;
    @(posedge clk); #1; flag_clr = 0; ovr_clr = 0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      if (done_flag) seen = 1;
    end
    chk(seen, tag, 0, 1);
  endtask

  task automatic wait_starts(input int n);
    for (int k = 0; k < 400 && n_start < n; k++) @(negedge clk);
  endtask

  task automatic chk_seq(input int n, input string tag);
    chk(n_start == n, tag, n_start, n);
    for (int k = 0; k < n && k < 16; k++) chk(seq[k] == k, tag, seq[k], k);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!queue_active, "R1 active", queue_active, 0);
    chk(cmd_idx == 0, "R1 idx", cmd_idx, 0);
    chk(!conv_start && !done_flag && !done_irq && !trig_ovr, "R1 outputs",
        {conv_start, done_flag, done_irq, trig_ovr}, 0);
    chk(mode_rd == SW, "R1 mode", mode_rd, SW);

    // R4 R5 R6 R13: software mode sweep over marker position and latency
    for (int ep = 0; ep < 5; ep++) begin
      for (int l = 0; l < 3; l++) begin
        end_pos = (ep == 4) ? 7 : ep;
        lat = l;
        n_start = 0;
        cfg(SW, 1, 1);
        @(posedge clk); @(negedge clk);
        chk(queue_active, "R4 started", queue_active, 1);
        wait_done("R6 completes");
        chk_seq((ep == 4) ? QL : ep + 1, "R5 sequence");
        chk(!queue_active && cmd_idx == 0, "R6 idle", queue_active, 0);
        chk(done_irq, "R13 irq", done_irq, 1);
        idle_cycles(10);
        chk(n_start == ((ep == 4) ? QL : ep + 1), "R6 disarmed", n_start,
            (ep == 4) ? QL : ep + 1);
        chk(done_flag, "R13 sticky", done_flag, 1);
        clr(1, 0);
        @(negedge clk);
        chk(!done_flag && !done_irq, "R13 cleared", done_flag, 0);
      end
    end

    // R2: unarmed triggers ignored in each mode
    end_pos = 3; lat = 5; n_start = 0;
    cfg(EDGE, 0, 1); pulse(0); pulse(0); idle_cycles(5);
    chk(!queue_active && n_start == 0, "R2 edge", n_start, 0);
    cfg(TMR, 0, 1); pulse(1); pulse(1); idle_cycles(5);
    chk(!queue_active && n_start == 0, "R2 timer", n_start, 0);
    cfg(GATE, 0, 1);
    @(posedge clk); #1 ext_trig = 1;
    idle_cycles(6);
    chk(!queue_active && n_start == 0, "R2 gate", n_start, 0);
    @(posedge clk); #1 ext_trig = 0;

    // R3 R9 R7: edge mode
    cfg(EDGE, 0, 1);
    cfg(EDGE, 1, 1);
    cfg(EDGE, 0, 1);
    idle_cycles(3);
    chk(!queue_active, "R3 waits trigger", queue_active, 0);
    pulse(0);
    wait_starts(1);
    chk(queue_active, "R3 still armed", queue_active, 1);
    chk(!trig_ovr, "R9 no ovr yet", trig_ovr, 0);
    pulse(0);
    @(negedge clk);
    chk(trig_ovr, "R9 edge overrun", trig_ovr, 1);
    cfg(EDGE, 1, 1);
    cfg(EDGE, 0, 1);
    wait_done("R7 completes");
    chk_seq(4, "R7 sequence");
    clr(1, 1);
    @(negedge clk);
    chk(!trig_ovr, "R9 ovr cleared", trig_ovr, 1'b0);
    pulse(0); idle_cycles(10);
    chk(!queue_active && n_start == 4, "R7 no rearm", n_start, 4);

    // R10: timer mode
    n_start = 0;
    cfg(TMR, 1, 1);
    idle_cycles(5);
    chk(!queue_active, "R10 waits expiry", queue_active, 0);
    pulse(1);
    wait_starts(1);
    pulse(1);
    @(negedge clk);
    chk(trig_ovr, "R9 timer overrun", trig_ovr, 1);
    wait_done("R10 completes");
    chk_seq(4, "R10 sequence");
    clr(1, 1);
    pulse(1); idle_cycles(10);
    chk(!queue_active && n_start == 4, "R10 needs rearm", n_start, 4);
    n_start = 0;
    cfg(TMR, 1, 1);
    pulse(1);
    wait_done("R10 rearmed");
    chk_seq(4, "R10 restart");
    clr(1, 0);

    // R11: gated mode
    n_start = 0; lat = 2;
    cfg(GATE, 1, 1);
    @(negedge clk);
    chk(mode_rd == GATE, "R12 first queue takes gate", mode_rd, GATE);
    @(posedge clk); #1 ext_trig = 1;
    wait_starts(2);
    @(posedge clk); #1 ext_trig = 0;
    idle_cycles(20);
    chk(n_start == 2, "R11 paused", n_start, 2);
    chk(queue_active && cmd_idx == 2, "R11 held index", cmd_idx, 2);
    @(posedge clk); #1 ext_trig = 1;
    wait_done("R11 completes");
    @(posedge clk); #1 ext_trig = 0;
    chk_seq(4, "R11 sequence");
    chk(!trig_ovr, "R9 gate no overrun", trig_ovr, 0);
    clr(1, 0);

    // R8: mode change aborts
    lat = 10; n_start = 0; n_abort = 0;
    cfg(EDGE, 1, 1);
    pulse(0);
    wait_starts(1);
    repeat (2) @(posedge clk);
    cfg(SW, 1, 1);
    n_start = 0;
    @(negedge clk);
    chk(n_abort == 1, "R8 abort pulse", n_abort, 1);
    lat = 1;
    wait_done("R8 new mode runs");
    chk_seq(4, "R8 restart from zero");
    clr(1, 0);
    lat = 10; n_start = 0;
    cfg(EDGE, 1, 1);
    pulse(0);
    wait_starts(1);
    repeat (2) @(posedge clk);
    cfg(TMR, 0, 1);
    @(negedge clk);
    chk(!queue_active && cmd_idx == 0, "R8 idle after abort", queue_active, 0);
    chk(n_abort == 2, "R8 second abort", n_abort, 2);
    pulse(1); idle_cycles(10);
    chk(!queue_active && n_start == 1, "R8 unarmed new mode", n_start, 1);

    // R12: second queue refuses gated mode
    @(posedge clk); #1 q2_wr = 1; cfg_mode = TMR; cfg_scan_en = 0;
    @(posedge clk); #1 q2_wr = 0;
    @(posedge clk); #1 q2_wr = 1; cfg_mode = GATE; cfg_scan_en = 1;
    @(posedge clk); #1 q2_wr = 0;
    @(negedge clk);
    chk(q2_mode == TMR, "R12 mode kept", q2_mode, TMR);
    pulse(1); idle_cycles(3);
    chk(!q2_act, "R12 arm dropped", q2_act, 0);

    // R13: interrupt disabled
    lat = 0; end_pos = 1; n_start = 0;
    cfg(SW, 1, 0);
    wait_done("R13 completes");
    chk(!done_irq, "R13 irq masked", done_irq, 0);
    idle_cycles(5);
    chk(done_flag, "R13 flag held", done_flag, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule